// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block holds the waiting instructions for one class of functional unit, such as the floating-point add/subtract pipe. It has three entries. When an instruction issues, each of its two source operands arrives in one of two forms. It may come as a value. It may instead come as the tag of the station that will produce the value. A nonzero tag stands for the producer. A tag of zero means the operand is already present.

The pool watches a single result broadcast bus. The bus carries a 64-bit result and the tag of the station that produced it. Every waiting operand compares its pending tag against the bus. On a match, the operand takes the data and its tag drops to zero. An entry with both tags at zero may be started on the functional unit. The pool offers at most one entry per cycle, the ready entry with the lowest index. An entry is released when its own tag appears on the bus. Each entry's tag is fixed by its position: entries 0, 1 and 2 carry tags 1, 2 and 3. Tags 4 and 5 belong to stations in other pools.

Top module: `rs_pool`

## Requirements
- R1: After reset all entries are free: `iss_ready` is 1, `iss_tag` is 1, and `dsp_valid` is 0.
- R2: An issue is placed in the lowest-index free entry. `iss_tag` shows the tag of that entry, which is its index plus 1. Tags 1 to 3 name this pool's entries.
- R3: When all three entries are busy, `iss_ready` is 0. An issue attempt made then is dropped and changes no entry.
- R4: A source given with tag 0 takes its value from the issue port. An instruction issued with both tags at 0 is offered on the dispatch port in the next cycle, carrying its op, both values and its tag.
- R5: A pending source whose nonzero tag equals the tag on a valid broadcast loads the broadcast data. Its tag becomes 0 in the same clock edge.
- R6: A broadcast whose tag differs from a pending source's tag leaves that source pending.
- R7: A source issued with a nonzero tag that equals the tag on a valid broadcast in the same cycle takes the broadcast data at issue. It is then not left waiting.
- R8: When several entries are ready, the lowest index is offered first. One entry is offered per cycle, and only while `fu_ready` is 1. Each issued entry is offered exactly once.
- R9: A valid broadcast that carries a busy entry's own tag frees that entry at that clock edge. The entry may then be chosen for the next issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code of the issuing instruction |
| iss_qa | input | 4 | Producer tag of source A, 0 when value given |
| iss_va | input | 64 | Value of source A |
| iss_qb | input | 4 | Producer tag of source B, 0 when value given |
| iss_vb | input | 64 | Value of source B |
| iss_ready | output | 1 | A free entry exists |
| iss_tag | output | 4 | Tag of the entry the next issue will take |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 4 | Tag of the producing station |
| bc_data | input | 64 | Broadcast result |
| fu_ready | input | 1 | Functional unit can start an operation this cycle |
| dsp_valid | output | 1 | An entry is started this cycle |
| dsp_op | output | 4 | Op of the started entry |
| dsp_va | output | 64 | Source A value of the started entry |
| dsp_vb | output | 64 | Source B value of the started entry |
| dsp_tag | output | 4 | Tag of the started entry |

## Verification
Several issue patterns exercise the operand path, and each one separates a different way of finding the operand. The first gives both values at issue. The second leaves one source waiting and then sends a broadcast with the wrong tag, followed by one with the right tag. This shows that capture is tied to the tag and not to the mere presence of a broadcast. The third issues while the awaited result is on the bus in that same cycle, which exposes a design that latches the stale tag. A last pattern fills the pool with three entries that all wait on one producer and then releases them with a single broadcast. This checks that a dropped issue leaves the pool unchanged, that starts happen in index order, and that a freed middle entry is the next one allocated.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N        = 3,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qa,
  input  logic [DATA_W-1:0] iss_va,
  input  logic [TAG_W-1:0]  iss_qb,
  input  logic [DATA_W-1:0] iss_vb,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              fu_ready,
  output logic              dsp_valid,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_va,
  output logic [DATA_W-1:0] dsp_vb,
  output logic [TAG_W-1:0]  dsp_tag
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      busy, sent, rdy;
  logic [OP_W-1:0]   op_q [N];
  logic [TAG_W-1:0]  qa_q [N];
  logic [TAG_W-1:0]  qb_q [N];
  logic [DATA_W-1:0] va_q [N];
  logic [DATA_W-1:0] vb_q [N];

  logic [IDX_W-1:0] free_idx, dsp_idx;
  logic             take;

  function automatic logic snoop(input logic [TAG_W-1:0] q);
    return bc_valid && (q != '0) && (q == bc_tag);
  endfunction

  always_comb begin
    free_idx = '0;
    dsp_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      rdy[i] = busy[i] && !sent[i] && (qa_q[i] == '0) && (qb_q[i] == '0);
      if (!busy[i]) free_idx = IDX_W'(i);
      if (rdy[i])   dsp_idx  = IDX_W'(i);
    end
  end

  assign iss_ready = ~&busy;
  assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
  assign take      = iss_valid && iss_ready;

  assign dsp_valid = fu_ready && (|rdy);
  assign dsp_op    = op_q[dsp_idx];
  assign dsp_va    = va_q[dsp_idx];
  assign dsp_vb    = vb_q[dsp_idx];
  assign dsp_tag   = TAG_W'(TAG_BASE) + TAG_W'(dsp_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      sent <= '0;
      for (int i = 0; i < N; i++) begin
        op_q[i] <= '0;
        qa_q[i] <= '0;
        qb_q[i] <= '0;
        va_q[i] <= '0;
        vb_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (take && free_idx == IDX_W'(i)) begin
          busy[i] <= 1'b1;
          sent[i] <= 1'b0;
          op_q[i] <= iss_op;
          qa_q[i] <= snoop(iss_qa) ? '0 : iss_qa;
          va_q[i] <= snoop(iss_qa) ? bc_data : iss_va;
          qb_q[i] <= snoop(iss_qb) ? '0 : iss_qb;
          vb_q[i] <= snoop(iss_qb) ? bc_data : iss_vb;
        end else if (busy[i]) begin
          if (bc_valid && bc_tag == TAG_W'(TAG_BASE + i)) busy[i] <= 1'b0;
          if (snoop(qa_q[i])) begin
            va_q[i] <= bc_data;
            qa_q[i] <= '0;
          end
          if (snoop(qb_q[i])) begin
            vb_q[i] <= bc_data;
            qb_q[i] <= '0;
          end
          if (dsp_valid && dsp_idx == IDX_W'(i)) sent[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N        = 3,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [TAG_W-1:0] iss_tag,
  input logic             bc_valid,
  input logic [TAG_W-1:0] bc_tag,
  input logic             fu_ready,
  input logic             dsp_valid,
  input logic [TAG_W-1:0] dsp_tag
);
  function automatic logic own(input logic [TAG_W-1:0] t);
    return (int'(t) >= TAG_BASE) && (int'(t) < TAG_BASE + N);
  endfunction

  p_dsp_needs_fu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> fu_ready);

  p_dsp_tag_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> own(dsp_tag));

  p_iss_tag_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> own(iss_tag));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_ready && !(bc_valid && own(bc_tag))) |=> !iss_ready);

  p_free_on_bc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && own(bc_tag) && !(iss_valid && iss_ready)) |=> iss_ready);
endmodule

bind rs_pool rs_pool_chk #(.N(N), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .fu_ready(fu_ready),
  .dsp_valid(dsp_valid), .dsp_tag(dsp_tag)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        iss_valid = 0, bc_valid = 0, fu_ready = 0;
  logic [3:0]  iss_op = 0, iss_qa = 0, iss_qb = 0, bc_tag = 0;
  logic [63:0] iss_va = 0, iss_vb = 0, bc_data = 0;
  logic        iss_ready, dsp_valid;
  logic [3:0]  iss_tag, dsp_op, dsp_tag;
  logic [63:0] dsp_va, dsp_vb;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_pool dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_qa(iss_qa), .iss_va(iss_va),
    .iss_qb(iss_qb), .iss_vb(iss_vb), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .fu_ready(fu_ready),
    .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_va(dsp_va), .dsp_vb(dsp_vb),
    .dsp_tag(dsp_tag)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] qa, input logic [63:0] va,
                       input logic [3:0] qb, input logic [63:0] vb);
    iss_valid = 1; iss_op = op; iss_qa = qa; iss_va = va; iss_qb = qb; iss_vb = vb;
    @(negedge clk);
    iss_valid = 0;
    #1;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [63:0] data);
    bc_valid = 1; bc_tag = tag; bc_data = data;
    @(negedge clk);
    bc_valid = 0;
    #1;
  endtask

  task automatic t_reset();
    fu_ready = 1; #1;
    check("R1", "iss_ready", iss_ready, 1);
    check("R1", "iss_tag", iss_tag, 1);
    check("R1", "dsp_valid", dsp_valid, 0);
  endtask

  task automatic t_direct();
    fu_ready = 0;
    issue(4'h3, 0, 64'hA0A0, 0, 64'hB0B0);
    check("R8", "dsp_valid held off by fu_ready", dsp_valid, 0);
    check("R2", "next iss_tag", iss_tag, 2);
    fu_ready = 1; #1;
    check("R4", "dsp_valid", dsp_valid, 1);
    check("R4", "dsp_op", dsp_op, 3);
    check("R4", "dsp_va", dsp_va, 64'hA0A0);
    check("R4", "dsp_vb", dsp_vb, 64'hB0B0);
    check("R4", "dsp_tag", dsp_tag, 1);
    @(negedge clk); #1;
    check("R8", "offered once", dsp_valid, 0);
    bcast(4'd1, 64'h1);
    check("R9", "iss_tag after free", iss_tag, 1);
    check("R9", "iss_ready after free", iss_ready, 1);
  endtask

  task automatic t_snoop();
    fu_ready = 1;
    issue(4'h5, 4'd5, 64'h0, 0, 64'h2222);
    check("R5", "pending not offered", dsp_valid, 0);
    bcast(4'd4, 64'hDEAD);
    check("R6", "wrong tag not captured", dsp_valid, 0);
    bcast(4'd5, 64'h5555);
    check("R5", "dsp_valid after capture", dsp_valid, 1);
    check("R5", "dsp_va captured", dsp_va, 64'h5555);
    check("R5", "dsp_vb kept", dsp_vb, 64'h2222);
    bcast(4'd1, 64'h0);
    check("R9", "iss_tag after free", iss_tag, 1);
  endtask

  task automatic t_bypass();
    fu_ready = 1;
    bc_valid = 1; bc_tag = 4'd4; bc_data = 64'hE1E1;
    issue(4'h6, 0, 64'h1234, 4'd4, 64'hBAD);
    bc_valid = 0;
    check("R7", "dsp_valid after bypass", dsp_valid, 1);
    check("R7", "dsp_vb from bus", dsp_vb, 64'hE1E1);
    check("R7", "dsp_va", dsp_va, 64'h1234);
    bcast(4'd1, 64'h0);
    check("R9", "iss_tag after free", iss_tag, 1);
  endtask

  task automatic t_full();
    fu_ready = 0;
    for (int i = 0; i < 3; i++) begin
      check("R2", "iss_tag before fill", iss_tag, 64'(i + 1));
      issue(4'(i + 1), 4'd5, 64'h0, 0, 64'(100 + i));
    end
    check("R3", "iss_ready when full", iss_ready, 0);
    issue(4'h7, 0, 64'h7777, 0, 64'h7777);
    fu_ready = 1; #1;
    check("R3", "dropped issue not offered", dsp_valid, 0);
    fu_ready = 0;
    bcast(4'd5, 64'hF00D);
    check("R8", "no offer without fu_ready", dsp_valid, 0);
    fu_ready = 1; #1;
    for (int i = 0; i < 3; i++) begin
      check("R8", "dsp_valid in order", dsp_valid, 1);
      check("R8", "dsp_tag in order", dsp_tag, 64'(i + 1));
      check("R3", "dsp_op unchanged", dsp_op, 64'(i + 1));
      check("R5", "dsp_va from shared producer", dsp_va, 64'hF00D);
      check("R4", "dsp_vb", dsp_vb, 64'(100 + i));
      @(negedge clk); #1;
    end
    check("R8", "all offered once", dsp_valid, 0);
    bcast(4'd2, 64'h0);
    check("R9", "iss_ready after middle free", iss_ready, 1);
    check("R2", "lowest free is middle", iss_tag, 2);
    bcast(4'd1, 64'h0);
    bcast(4'd3, 64'h0);
    check("R9", "iss_tag after all free", iss_tag, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_snoop();
    t_bypass();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule